// File: doc/BRIEF.md
# Protected PLL Control Register

This block is a byte-wide control register for an on-chip clock multiplier. It sits on a simple CPU bus with address, write strobe, write data and combinational read data. It holds two things: an enable bit that turns the multiplier on, and a 3-bit code that selects the multiplication factor. Alongside the register bits it drives the enable and the decoded factor (2, 4 or 6) to the clock generator.

The register is guarded in three ways. No write lands unless an external unlock bit, owned by a separate protection register, is 1. The factor code can change only once after reset, and only while the multiplier is off. The multiplier can be switched on only when the clock tree is in a safe state: the main clock is selected as system clock, the clock divider is set to undivided, and the divider-mode control is inactive. Each refused write raises a one-cycle error flag that names why it was refused. A parameter decides whether the factor-6 code exists in this variant.

Top module: `pll_ctl_reg`

## Requirements
- R1: After reset the enable is 0, the code is 010 (factor 4), every error flag is 0, and a read of the register address returns 0x0A.
- R2: A read of the register address returns {enable, 0, 0, 0, 1, code[2:0]} from bit 7 down to bit 0, whatever was written to bits 6:3. Any other address reads 0x00.
- R3: A write to the register address while unlock_i is 0 changes nothing, and err_locked_o is 1 for exactly the one cycle after the write edge.
- R4: mult_factor_o is the factor selected by the current code. Code 001 gives 2, 010 gives 4, and 011 gives 6 when MUL6_EN is 1.
- R5: An unlocked write whose bits 2:0 carry a prohibited code (000 or 100 to 111) leaves the code unchanged and pulses err_mult_o for one cycle.
- R6: The first unlocked write whose bits 2:0 carry a legal code that differs from the current code, made while the enable is 0, loads that code. After that, every unlocked write carrying a different code is refused with err_mult_o until reset. A write carrying the current code is neither an update nor an error.
- R7: An unlocked write carrying a code that differs from the current code, made while the enable is 1, leaves the code unchanged and pulses err_mult_o.
- R8: An unlocked write with bit 7 set, made while the enable is 0, sets the enable only if sysclk_main_i is 1, div_sel_i is 00 and div_mode_i is 0. Otherwise the enable stays 0 and err_enable_o pulses for one cycle.
- R9: An unlocked write with bit 7 clear always clears the enable.
- R10: A single write that sets the enable and changes the code checks the code rule against the enable value held before the write. Both updates show on the outputs after the same clock edge.
- R11: With MUL6_EN at 0, code 011 is treated as a prohibited code.
- R12: Writes to any other address change no state and raise no error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| unlock_i | input | 1 | Write permission from the protection register |
| sysclk_main_i | input | 1 | 1 when the system clock is taken from the main oscillator |
| div_sel_i | input | 2 | Current system clock divider select, 00 means undivided |
| div_mode_i | input | 1 | Divider-mode control, must be 0 before enabling |
| pll_en_o | output | 1 | Multiplier enable |
| mult_factor_o | output | 3 | Decoded factor: 2, 4 or 6 |
| err_locked_o | output | 1 | One-cycle pulse: write refused because locked |
| err_enable_o | output | 1 | One-cycle pulse: enable refused, clock tree not safe |
| err_mult_o | output | 1 | One-cycle pulse: code change refused |

## Verification
The assertions assume that each write strobe is a single-cycle pulse, and that the clock-tree status inputs and unlock_i are steady across the edge on which the write is sampled. The enable-precondition property looks one cycle back at those inputs. The stimulus changes status inputs, unlock and data only at the falling edge and holds them through the write edge. It mixes safe and unsafe clock settings and locked and unlocked writes, with mostly on-target and a few off-target addresses. It resets the block at regular intervals so that the write-once code gets exercised more than once. A second instance with the factor-6 code disabled gets the same stimulus.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int DATA_W = 8;

  typedef logic [2:0] mcode_t;

  localparam mcode_t RESET_CODE = 3'b010;

  typedef struct packed {
    logic locked;
    logic enable;
    logic mult;
  } err_t;

  // Legal factor codes; 011 only when the x6 variant is present
  function automatic logic code_ok(input mcode_t c, input logic x6);
    return (c == 3'b001) || (c == 3'b010) || (x6 && (c == 3'b011));
  endfunction

  // Legal codes map to twice their low two bits
  function automatic logic [2:0] code_to_factor(input mcode_t c, input logic x6);
    return code_ok(c, x6) ? {c[1:0], 1'b0} : 3'd0;
  endfunction

  // Read view: reserved bit 3 reads 1, bits 6:4 read 0
  function automatic logic [DATA_W-1:0] pack_view(input logic en, input mcode_t c);
    return {en, 2'b00, 1'b0, 1'b1, c};
  endfunction
endpackage

// File: rtl/pll_ctl_busif.sv
module pll_ctl_busif
  import pll_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h1C
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              unlock,
  input  logic              en_cur,
  input  mcode_t            code_cur,
  output logic              wr_hit,
  output logic              wr_ok,
  output logic              wr_blocked,
  output logic [DATA_W-1:0] rdata
);
  logic hit;

  always_comb begin
    hit        = (addr == REG_ADDR);
    wr_hit     = wr && hit;
    wr_ok      = wr_hit && unlock;
    wr_blocked = wr_hit && !unlock;
    rdata      = hit ? pack_view(en_cur, code_cur) : '0;
  end
endmodule

// File: rtl/pll_ctl_mult.sv
module pll_ctl_mult
  import pll_ctl_pkg::*;
#(
  parameter bit MUL6_EN = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_ok,
  input  mcode_t wr_code,
  input  logic   en_cur,
  output mcode_t code_q,
  output logic   once_q,
  output logic   mult_accept,
  output logic   mult_reject
);
  logic changing;

  always_comb begin
    changing    = wr_ok && (wr_code != code_q);
    mult_accept = changing && !en_cur && !once_q && code_ok(wr_code, MUL6_EN);
    mult_reject = changing && !mult_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RESET_CODE;
      once_q <= 1'b0;
    end else if (mult_accept) begin
      code_q <= wr_code;
      once_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pll_ctl_en.sv
module pll_ctl_en (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic       wr_bit,
  input  logic       sys_main,
  input  logic [1:0] div_sel,
  input  logic       div_mode,
  output logic       en_q,
  output logic       clk_safe,
  output logic       en_accept,
  output logic       en_reject,
  output logic       en_clear
);
  logic turn_on;

  always_comb begin
    clk_safe  = sys_main && (div_sel == 2'b00) && !div_mode;
    turn_on   = wr_ok && wr_bit && !en_q;
    en_accept = turn_on && clk_safe;
    en_reject = turn_on && !clk_safe;
    en_clear  = wr_ok && !wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= 1'b0;
    else if (en_accept) en_q <= 1'b1;
    else if (en_clear)  en_q <= 1'b0;
  end
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pll_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h1C,
  parameter bit MUL6_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              unlock_i,
  input  logic              sysclk_main_i,
  input  logic [1:0]        div_sel_i,
  input  logic              div_mode_i,
  output logic              pll_en_o,
  output logic [2:0]        mult_factor_o,
  output logic              err_locked_o,
  output logic              err_enable_o,
  output logic              err_mult_o
);
  localparam int EN_BIT = DATA_W - 1;

  logic   wr_hit, wr_ok, wr_blocked;
  logic   en_q, clk_safe, en_accept, en_reject, en_clear;
  mcode_t code_q;
  logic   mult_once, mult_accept, mult_reject;
  err_t   err_d, err_q;
  logic [3:0] wdata_unused;

  assign wdata_unused = bus_wdata[6:3];

  pll_ctl_busif #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_busif (
    .addr(bus_addr), .wr(bus_wr), .unlock(unlock_i),
    .en_cur(en_q), .code_cur(code_q),
    .wr_hit(wr_hit), .wr_ok(wr_ok), .wr_blocked(wr_blocked),
    .rdata(bus_rdata)
  );

  pll_ctl_mult #(.MUL6_EN(MUL6_EN)) u_mult (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_code(bus_wdata[2:0]),
    .en_cur(en_q), .code_q(code_q), .once_q(mult_once),
    .mult_accept(mult_accept), .mult_reject(mult_reject)
  );

  pll_ctl_en u_en (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_bit(bus_wdata[EN_BIT]),
    .sys_main(sysclk_main_i), .div_sel(div_sel_i), .div_mode(div_mode_i),
    .en_q(en_q), .clk_safe(clk_safe), .en_accept(en_accept),
    .en_reject(en_reject), .en_clear(en_clear)
  );

  always_comb begin
    err_d.locked = wr_blocked;
    err_d.enable = en_reject;
    err_d.mult   = mult_reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  assign pll_en_o      = en_q;
  assign mult_factor_o = code_to_factor(code_q, MUL6_EN);
  assign err_locked_o  = err_q.locked;
  assign err_enable_o  = err_q.enable;
  assign err_mult_o    = err_q.mult;
endmodule

// File: rtl/pll_ctl_reg_chk.sv
module pll_ctl_reg_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h1C,
  parameter bit MUL6_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              unlock_i,
  input logic              sysclk_main_i,
  input logic [1:0]        div_sel_i,
  input logic              div_mode_i,
  input logic              pll_en_o,
  input logic [2:0]        mult_factor_o,
  input logic              err_locked_o,
  input logic              err_enable_o,
  input logic              err_mult_o,
  input logic              mult_accept
);
  logic hit, accept_seen;
  assign hit = (bus_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           accept_seen <= 1'b0;
    else if (mult_accept) accept_seen <= 1'b1;
  end

  assert_read_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bus_rdata[6:3] == 4'b0001) && (bus_rdata[7] == pll_en_o));

  assert_locked_noeffect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && !unlock_i) |=> ($stable(pll_en_o) && $stable(mult_factor_o) && err_locked_o));

  assert_factor_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_factor_o == 3'd2) || (mult_factor_o == 3'd4) || (MUL6_EN && (mult_factor_o == 3'd6)));

  assert_mult_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_mult_o |-> $past(bus_wr && hit && unlock_i));

  assert_mult_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_seen |-> !mult_accept);

  assert_mult_frozen_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en_o |=> $stable(mult_factor_o));

  assert_en_precond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en_o) |-> $past(bus_wr && hit && unlock_i && sysclk_main_i
                              && (div_sel_i == 2'b00) && !div_mode_i));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && unlock_i && !bus_wdata[7]) |=> !pll_en_o);

  assert_offaddr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> ($stable(pll_en_o) && $stable(mult_factor_o)
                          && !err_locked_o && !err_enable_o && !err_mult_o));
endmodule

bind pll_ctl_reg pll_ctl_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .MUL6_EN(MUL6_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlock_i(unlock_i),
  .sysclk_main_i(sysclk_main_i), .div_sel_i(div_sel_i), .div_mode_i(div_mode_i),
  .pll_en_o(pll_en_o), .mult_factor_o(mult_factor_o), .err_locked_o(err_locked_o),
  .err_enable_o(err_enable_o), .err_mult_o(err_mult_o), .mult_accept(mult_accept)
);

// File: tb/pll_ctl_reg_test.sv
module pll_ctl_reg_test;
  localparam logic [7:0] REG = 8'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = REG;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic unlock = 1'b0, sys_main = 1'b1, div_mode = 1'b0;
  logic [1:0] div_sel = 2'b00;

  logic [7:0] rd [2];
  logic       en_o [2], elk [2], een [2], emu [2];
  logic [2:0] fac [2];

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  // model state, index 0 = x6 present, 1 = x6 absent
  logic       m_en [2], m_lock [2], x_lk [2], x_en [2], x_mu [2];
  logic [2:0] m_code [2];

  always #5 clk = ~clk;

  pll_ctl_reg #(.ADDR_W(8), .REG_ADDR(REG), .MUL6_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[0]), .unlock_i(unlock), .sysclk_main_i(sys_main), .div_sel_i(div_sel),
    .div_mode_i(div_mode), .pll_en_o(en_o[0]), .mult_factor_o(fac[0]),
    .err_locked_o(elk[0]), .err_enable_o(een[0]), .err_mult_o(emu[0]));

  pll_ctl_reg #(.ADDR_W(8), .REG_ADDR(REG), .MUL6_EN(1'b0)) uut_nox6 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[1]), .unlock_i(unlock), .sysclk_main_i(sys_main), .div_sel_i(div_sel),
    .div_mode_i(div_mode), .pll_en_o(en_o[1]), .mult_factor_o(fac[1]),
    .err_locked_o(elk[1]), .err_enable_o(een[1]), .err_mult_o(emu[1]));

  function automatic logic [2:0] ref_factor(input logic [2:0] c, input logic x6);
    case (c)
      3'd1: return 3'd2;
      3'd2: return 3'd4;
      3'd3: return x6 ? 3'd6 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int u,
                       input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d: actual %h expected %h", req, what, u, act, exp);
    end
  endtask

  task automatic verify_all();
    for (int u = 0; u < 2; u++) begin
      check("R2", "rdata", u, rd[u], {m_en[u], 4'b0001, m_code[u]});
      check("R8", "enable", u, {7'd0, en_o[u]}, {7'd0, m_en[u]});
      check("R4", "factor", u, {5'd0, fac[u]}, {5'd0, ref_factor(m_code[u], u == 0)});
      check("R3", "err_locked", u, {7'd0, elk[u]}, {7'd0, x_lk[u]});
      check("R8", "err_enable", u, {7'd0, een[u]}, {7'd0, x_en[u]});
      check("R6", "err_mult", u, {7'd0, emu[u]}, {7'd0, x_mu[u]});
    end
  endtask

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_en[u] = 1'b0; m_lock[u] = 1'b0; m_code[u] = 3'b010;
      x_lk[u] = 1'b0; x_en[u] = 1'b0; x_mu[u] = 1'b0;
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    for (int u = 0; u < 2; u++) begin
      logic old_en;
      x_lk[u] = 1'b0; x_en[u] = 1'b0; x_mu[u] = 1'b0;
      old_en = m_en[u];
      if (a == REG) begin
        if (!unlock) x_lk[u] = 1'b1;
        else begin
          if (d[2:0] != m_code[u]) begin
            if (ref_factor(d[2:0], u == 0) == 3'd0 || old_en || m_lock[u]) x_mu[u] = 1'b1;
            else begin m_code[u] = d[2:0]; m_lock[u] = 1'b1; end
          end
          if (!d[7]) m_en[u] = 1'b0;
          else if (!old_en) begin
            if (sys_main && div_sel == 2'b00 && !div_mode) m_en[u] = 1'b1;
            else x_en[u] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = REG;
    #1 verify_all();
  endtask

  task automatic idle_check();
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin x_lk[u] = 1'b0; x_en[u] = 1'b0; x_mu[u] = 1'b0; end
    #1 verify_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = REG;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1 verify_all();
  endtask

  task automatic set_clk(input logic sm, input logic [1:0] ds, input logic dm);
    sys_main = sm; div_sel = ds; div_mode = dm;
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1D));
    model_reset();
    do_reset();
    // R1: reset state, read value 0x0A
    check("R1", "reset rdata", 0, rd[0], 8'h0A);
    check("R1", "reset factor", 0, {5'd0, fac[0]}, 8'd4);
    // R2: other address reads zero
    bus_addr = 8'h1D; #1 check("R2", "offaddr read", 0, rd[0], 8'h00);
    bus_addr = REG;
    // R3: locked write with safe clock
    unlock = 1'b0; set_clk(1'b1, 2'b00, 1'b0);
    bus_write(REG, 8'h81);
    check("R3", "locked err", 0, {7'd0, elk[0]}, 8'd1);
    idle_check();
    // R12: unlocked write elsewhere
    unlock = 1'b1;
    bus_write(8'h1B, 8'h81);
    // R5: prohibited codes
    bus_write(REG, 8'h00);
    check("R5", "code000 err", 0, {7'd0, emu[0]}, 8'd1);
    bus_write(REG, 8'h0D);
    check("R5", "code101 factor", 0, {5'd0, fac[0]}, 8'd4);
    // R6: same code, bits 6:3 garbage, no error
    bus_write(REG, 8'h7A);
    check("R6", "same code no err", 0, {7'd0, emu[0]}, 8'd0);
    // R8: each unsafe condition
    set_clk(1'b1, 2'b01, 1'b0); bus_write(REG, 8'h82);
    check("R8", "div not 00", 0, {7'd0, een[0]}, 8'd1);
    set_clk(1'b1, 2'b00, 1'b1); bus_write(REG, 8'h82);
    set_clk(1'b0, 2'b00, 1'b0); bus_write(REG, 8'h82);
    check("R8", "not main clk", 0, {7'd0, en_o[0]}, 8'd0);
    // R10: enable and code change together
    set_clk(1'b1, 2'b00, 1'b0); bus_write(REG, 8'h81);
    check("R10", "combined en", 0, {7'd0, en_o[0]}, 8'd1);
    check("R10", "combined factor", 0, {5'd0, fac[0]}, 8'd2);
    // R7: change while running
    bus_write(REG, 8'h82);
    check("R7", "running err", 1, {7'd0, emu[1]}, 8'd1);
    // R9: clear always accepted
    set_clk(1'b0, 2'b11, 1'b1); bus_write(REG, 8'h01);
    check("R9", "cleared", 0, {7'd0, en_o[0]}, 8'd0);
    // R6: second change refused
    bus_write(REG, 8'h02);
    check("R6", "write once", 0, {5'd0, fac[0]}, 8'd2);
    // R11: x6 code on both variants
    do_reset();
    bus_write(REG, 8'h03);
    check("R11", "x6 factor", 0, {5'd0, fac[0]}, 8'd6);
    check("R11", "nox6 err", 1, {7'd0, emu[1]}, 8'd1);
    check("R11", "nox6 factor", 1, {5'd0, fac[1]}, 8'd4);
    // random phase
    for (int it = 0; it < 600; it++) begin
      logic [7:0] a, d;
      if (it % 60 == 0) do_reset();
      unlock = ($urandom % 4) != 0;
      if ($urandom % 5 < 3) set_clk(1'b1, 2'b00, 1'b0);
      else set_clk(1'($urandom), 2'($urandom), 1'($urandom));
      a = ($urandom % 8 == 0) ? 8'($urandom) : REG;
      d = 8'($urandom);
      bus_write(a, d);
      if (it % 7 == 0) idle_check();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule